// File: doc/BRIEF.md
# Interrupt Aggregator with Deassertion Holdoff

This block merges a set of internal event sources into one level-sensitive interrupt request toward a host bus bridge. Some sources are captured in sticky status flops that software clears by writing one: the GPIO events, the general-purpose timer, the two bus-error events and a software-raised interrupt. The others are level inputs shown live: PHY, DMA and wake. These are cleared only where they originate. An enable register qualifies each source. A configuration register holds the master request enable and an 8-bit holdoff interval, counted in ticks of `TICK_DIV` core clocks (10 µs in the target clock domain). It also holds a write-only holdoff clear and two read-only flags.

After every falling edge of the request line, a holdoff window keeps the line low for the programmed interval, so a host service routine gets a guaranteed quiet period. An interval of zero turns the window off. The enabled wake source ignores both the holdoff and the master enable. A small state machine drives the request line. In `ST_IDLE` the line is low and no holdoff is running. `ST_IDLE -> ST_ACTIVE` happens when a qualified request or wake is present. In `ST_ACTIVE` the line is high. When the request goes away, `ST_ACTIVE -> ST_HOLD` is taken if the interval is nonzero, and `ST_ACTIVE -> ST_IDLE` is taken if it is zero. In `ST_HOLD` the line is low and the timer runs. `ST_HOLD -> ST_ACTIVE` happens on wake. `ST_HOLD -> ST_IDLE` happens when the timer expires or the clear bit is written.

Register layout, with GPIO_N = 3. The status and enable bits are: 0..2 GPIO, 3 timer, 4 slave bus error, 5 master bus error, 6 PHY, 7 DMA, 8 wake, 9 software. The configuration write fields are: [7:0] interval, [8] master enable, [9] holdoff clear. The configuration readback adds two flags: [10] holdoff running and [11] any enabled source active. Bit [9] always reads 0.

Top module: `irq_holdoff_agg`

## Requirements
- R1: A latched source bit (0..5, 9) is set on its event and holds until a write-one-to-clear on that bit. An event in the same cycle as a clear leaves the bit set.
- R2: Status bits 6 (PHY), 7 (DMA) and 8 (wake) follow their level inputs, and a write-one-to-clear has no effect on them.
- R3: Status bit 9 is set only by an enable-register write that takes enable bit 9 from 0 to 1. Rewriting it while it is already 1 does not set it again.
- R4: Status bits show each source's raw state whatever its enable bit holds.
- R5: With master enable set and no holdoff running, the request line rises one cycle after an enabled non-wake source becomes pending in status.
- R6: With master enable clear, no source except wake drives the request line.
- R7: With interval I nonzero, after the request line falls, the holdoff flag reads 1. The line then stays low for I*TICK_DIV+1 cycles even though an enabled source remains pending.
- R8: With interval 0, the holdoff flag stays 0 and the line can rise again on the cycle after it falls.
- R9: An enabled, active wake source raises the request line one cycle later, even during a holdoff and even with master enable clear. It also ends the holdoff.
- R10: Writing 1 to the holdoff clear bit ends a running holdoff in that write cycle. A still-pending request reasserts the line one cycle later.
- R11: The aggregate flag reads 1 whenever any enabled source is active, including during holdoff and with master enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_evt | input | GPIO_N | GPIO event pulses |
| gpt_evt | input | 1 | General-purpose timer event pulse |
| slv_err_evt | input | 1 | Slave bus error event pulse |
| mst_err_evt | input | 1 | Master bus error event pulse |
| phy_lvl | input | 1 | PHY interrupt level |
| dma_lvl | input | 1 | DMA interrupt level |
| wake_lvl | input | 1 | Wake interrupt level |
| sts_w1c | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | GPIO_N+7 | Status clear mask |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | GPIO_N+7 | Enable register write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration write data |
| sts_rd | output | GPIO_N+7 | Raw status readback |
| en_rd | output | GPIO_N+7 | Enable register readback |
| cfg_rd | output | 12 | Configuration readback with flags |
| irq_req | output | 1 | Level interrupt request to the host bridge |

## Verification
The hardest situation to reach is a falling edge of the request line while an enabled source is still pending. Only in that case does the holdoff visibly hold the line low. The stimulus keeps a timer event latched and toggles master enable off and back on in two consecutive writes. This forces a fall and then an immediate re-request, so the bench can count low cycles exactly. It uses a prescale of 4, which makes the count short. The same forced holdoff is the starting point for the wake-bypass and clear-control scenarios.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    localparam int IVW = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } req_state_t;
endpackage

// File: rtl/irqagg_status.sv
`timescale 1ns/1ps
module irqagg_status #(
    parameter int NSRC = 10,
    parameter logic [NSRC-1:0] LATCH_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] lvl_in,
    input  logic [NSRC-1:0] w1c_mask,
    output logic [NSRC-1:0] raw
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LATCH_MASK[i]) begin : g_lat
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            q <= 1'b0;
                else if (set_evt[i])   q <= 1'b1;
                else if (w1c_mask[i])  q <= 1'b0;
            end
            assign raw[i] = q;

            // R1
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (q && !w1c_mask[i]) |=> q);
        end else begin : g_lvl
            assign raw[i] = lvl_in[i];
        end
    end
endmodule

// File: rtl/irqagg_holdtimer.sv
`timescale 1ns/1ps
module irqagg_holdtimer #(
    parameter int TICK_DIV = 2000,
    parameter int IVW      = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           abort,
    input  logic [IVW-1:0] interval,
    output logic           running,
    output logic           done
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0]  pre;
    logic [IVW-1:0] cnt;
    logic           tick;

    assign running = (cnt != '0);
    assign tick    = running && (pre == PW'(TICK_DIV - 1));
    assign done    = tick && (cnt == IVW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (start) begin
            pre <= '0;
            cnt <= interval;
        end else if (abort) begin
            pre <= '0;
            cnt <= '0;
        end else if (running) begin
            if (tick) begin
                pre <= '0;
                cnt <= cnt - IVW'(1);
            end else begin
                pre <= pre + PW'(1);
            end
        end
    end

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !start && !abort) |=> $stable(cnt));
endmodule

// File: rtl/irqagg_fsm.sv
`timescale 1ns/1ps
module irqagg_fsm
    import irqagg_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_gated,
    input  logic          wake_req,
    input  logic [IW-1:0] interval,
    input  logic          clr_hold,
    input  logic          hold_done,
    output logic          hold_start,
    output logic          hold_active,
    output logic          irq
);
    req_state_t state, nxt;
    logic       want;

    assign want = req_gated || wake_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (want) nxt = ST_ACTIVE;
            ST_ACTIVE: if (!want) nxt = (interval != '0) ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (wake_req)                    nxt = ST_ACTIVE;
                else if (clr_hold || hold_done)  nxt = ST_IDLE;
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        irq         = (state == ST_ACTIVE);
        hold_active = (state == ST_HOLD);
        hold_start  = (state == ST_ACTIVE) && (nxt == ST_HOLD);
    end

    // R6
    master_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_gated && !wake_req) |=> !irq);
    // R9
    wake_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> irq);
    // R8
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0 && !hold_active) |=> !hold_active);
    // R7
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !wake_req && !clr_hold && !hold_done) |=> (hold_active && !irq));
    // R10
    clear_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && clr_hold && !wake_req) |=> !hold_active);
endmodule

// File: rtl/irq_holdoff_agg.sv
`timescale 1ns/1ps
module irq_holdoff_agg
    import irqagg_pkg::*;
#(
    parameter int GPIO_N   = 3,
    parameter int TICK_DIV = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GPIO_N-1:0]    gpio_evt,
    input  logic                 gpt_evt,
    input  logic                 slv_err_evt,
    input  logic                 mst_err_evt,
    input  logic                 phy_lvl,
    input  logic                 dma_lvl,
    input  logic                 wake_lvl,
    input  logic                 sts_w1c,
    input  logic [GPIO_N+6:0]    sts_wdata,
    input  logic                 en_wr,
    input  logic [GPIO_N+6:0]    en_wdata,
    input  logic                 cfg_wr,
    input  logic [IVW+1:0]       cfg_wdata,
    output logic [GPIO_N+6:0]    sts_rd,
    output logic [GPIO_N+6:0]    en_rd,
    output logic [IVW+3:0]       cfg_rd,
    output logic                 irq_req
);
    localparam int NSRC   = GPIO_N + 7;
    localparam int B_PHY  = GPIO_N + 3;
    localparam int B_WAKE = GPIO_N + 5;
    localparam int B_SW   = GPIO_N + 6;
    localparam int C_MEN  = IVW;
    localparam int C_CLR  = IVW + 1;
    localparam logic [NSRC-1:0] LMASK     = ~(NSRC'(7) << B_PHY);
    localparam logic [NSRC-1:0] WAKE_BIT  = NSRC'(1) << B_WAKE;

    logic [NSRC-1:0] en_q, raw, pend, set_evt, lvl_vec, w1c_vec;
    logic [IVW-1:0]  iv_q;
    logic            men_q;
    logic            sw_set, wake_req, req_gated, any_act, clr_hold;
    logic            hold_start, hold_active, hold_done, tmr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            iv_q  <= '0;
            men_q <= 1'b0;
        end else begin
            if (en_wr)  en_q <= en_wdata;
            if (cfg_wr) begin
                iv_q  <= cfg_wdata[IVW-1:0];
                men_q <= cfg_wdata[C_MEN];
            end
        end
    end

    assign sw_set  = en_wr && en_wdata[B_SW] && !en_q[B_SW];
    assign set_evt = {sw_set, 3'b000, mst_err_evt, slv_err_evt, gpt_evt, gpio_evt};
    assign lvl_vec = {1'b0, wake_lvl, dma_lvl, phy_lvl, {(GPIO_N+3){1'b0}}};
    assign w1c_vec = sts_w1c ? sts_wdata : '0;

    irqagg_status #(.NSRC(NSRC), .LATCH_MASK(LMASK)) u_status (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .lvl_in(lvl_vec),
        .w1c_mask(w1c_vec), .raw(raw)
    );

    assign pend      = raw & en_q;
    assign wake_req  = pend[B_WAKE];
    assign req_gated = men_q && |(pend & ~WAKE_BIT);
    assign any_act   = |pend;
    assign clr_hold  = cfg_wr && cfg_wdata[C_CLR];

    irqagg_holdtimer #(.TICK_DIV(TICK_DIV), .IVW(IVW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(hold_start), .abort(clr_hold || !hold_active),
        .interval(iv_q), .running(tmr_run), .done(hold_done)
    );

    irqagg_fsm #(.IW(IVW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_gated(req_gated), .wake_req(wake_req),
        .interval(iv_q), .clr_hold(clr_hold), .hold_done(hold_done),
        .hold_start(hold_start), .hold_active(hold_active), .irq(irq_req)
    );

    assign sts_rd = raw;
    assign en_rd  = en_q;
    assign cfg_rd = {any_act, hold_active, 1'b0, men_q, iv_q};

    // R7
    timer_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !clr_hold && !wake_req && !hold_done) |=> tmr_run);
    // R3
    sw_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_q[B_SW] && !raw[B_SW]) |=> !raw[B_SW]);
endmodule

// File: tb/irq_holdoff_agg_bench.sv
`timescale 1ns/1ps
module irq_holdoff_agg_bench;
    localparam int G   = 3;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [G-1:0] gpio_evt = '0;
    logic        gpt_evt = 0, slv_err_evt = 0, mst_err_evt = 0;
    logic        phy_lvl = 0, dma_lvl = 0, wake_lvl = 0;
    logic        sts_w1c = 0, en_wr = 0, cfg_wr = 0;
    logic [9:0]  sts_wdata = '0, en_wdata = '0, cfg_wdata = '0;
    logic [9:0]  sts_rd, en_rd;
    logic [11:0] cfg_rd;
    logic        irq_req;
    int          n_tests = 0, n_fail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    irq_holdoff_agg #(.GPIO_N(G), .TICK_DIV(DIV)) u_irq_holdoff_agg (
        .clk(clk), .rst_n(rst_n), .gpio_evt(gpio_evt), .gpt_evt(gpt_evt),
        .slv_err_evt(slv_err_evt), .mst_err_evt(mst_err_evt), .phy_lvl(phy_lvl),
        .dma_lvl(dma_lvl), .wake_lvl(wake_lvl), .sts_w1c(sts_w1c), .sts_wdata(sts_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sts_rd(sts_rd), .en_rd(en_rd), .cfg_rd(cfg_rd), .irq_req(irq_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic w1c(logic [9:0] d);
        sts_w1c = 1; sts_wdata = d; tick(); sts_w1c = 0; sts_wdata = '0;
    endtask

    task automatic wr_en(logic [9:0] d);
        en_wr = 1; en_wdata = d; tick(); en_wr = 0;
    endtask

    task automatic wr_cfg(logic [9:0] d);
        cfg_wr = 1; cfg_wdata = d; tick(); cfg_wr = 0;
    endtask

    task automatic pulse_gpt;
        gpt_evt = 1; tick(); gpt_evt = 0;
    endtask

    task automatic cleanup;
        w1c(10'h3FF); wr_en(10'h000); wr_cfg(10'h200); wr_cfg(10'h000); tick(2);
    endtask

    // forces a fall with the timer source still pending
    task automatic force_fall(logic [7:0] iv);
        wr_cfg({2'b01, iv}); wr_en(10'h008 | en_rd); pulse_gpt(); tick();
        chk("R5 line up before fall", irq_req, 1);
        wr_cfg({2'b00, iv}); wr_cfg({2'b01, iv});
    endtask

    task automatic t_reset;
        chk("R5 reset irq", irq_req, 0);
        chk("R4 reset status", sts_rd, 0);
        chk("R11 reset cfg", cfg_rd, 0);
    endtask

    task automatic t_latch;
        gpio_evt = 3'b010; tick(); gpio_evt = 0;
        chk("R4 raw shown while disabled", sts_rd, 10'h002);
        tick(3);
        chk("R1 sticky hold", sts_rd, 10'h002);
        chk("R6 no request while disabled", irq_req, 0);
        w1c(10'h002);
        chk("R1 w1c clears", sts_rd, 10'h000);
        gpio_evt = 3'b100; sts_w1c = 1; sts_wdata = 10'h004; tick();
        gpio_evt = 0; sts_w1c = 0;
        chk("R1 set wins over clear", sts_rd, 10'h004);
        cleanup();
    endtask

    task automatic t_level;
        phy_lvl = 1; tick();
        chk("R2 phy level", sts_rd, 10'h040);
        w1c(10'h040);
        chk("R2 w1c ignored", sts_rd, 10'h040);
        phy_lvl = 0; dma_lvl = 1; tick();
        chk("R2 dma level", sts_rd, 10'h080);
        dma_lvl = 0; tick();
        chk("R2 level drops", sts_rd, 10'h000);
    endtask

    task automatic t_sw;
        wr_en(10'h200);
        chk("R3 rising enable sets", sts_rd, 10'h200);
        w1c(10'h200);
        chk("R3 cleared", sts_rd, 10'h000);
        wr_en(10'h200);
        chk("R3 no retrigger when already 1", sts_rd, 10'h000);
        wr_en(10'h000); wr_en(10'h200);
        chk("R3 second rising edge", sts_rd, 10'h200);
        cleanup();
    endtask

    task automatic t_master;
        wr_cfg(10'h100); wr_en(10'h008); pulse_gpt();
        chk("R5 one cycle latency", irq_req, 0);
        tick();
        chk("R5 request up", irq_req, 1);
        wr_cfg(10'h000); tick();
        chk("R6 master off blocks", irq_req, 0);
        chk("R4 status kept", sts_rd, 10'h008);
        chk("R11 aggregate with master off", cfg_rd[11], 1);
        wr_cfg(10'h100); tick();
        chk("R5 master back on", irq_req, 1);
        w1c(10'h008); tick();
        chk("R5 falls after clear", irq_req, 0);
        cleanup();
    endtask

    task automatic t_hold(logic [7:0] iv, int exp_low, string tag);
        int cnt;
        force_fall(iv);
        chk({tag, " hold flag"}, cfg_rd[10], (iv != 0));
        chk("R11 aggregate during hold", cfg_rd[11], 1);
        cnt = 0;
        while (irq_req == 0 && cnt < 1000) begin
            cnt++; tick();
        end
        chk({tag, " low cycles"}, cnt, exp_low);
        chk({tag, " hold flag after"}, cfg_rd[10], 0);
        cleanup();
    endtask

    task automatic t_wake;
        wr_en(10'h100);
        force_fall(8'd10);
        tick(3);
        chk("R7 held low", irq_req, 0);
        chk("R7 flag set", cfg_rd[10], 1);
        wake_lvl = 1; tick();
        chk("R9 wake breaks holdoff", irq_req, 1);
        chk("R9 holdoff ended", cfg_rd[10], 0);
        wr_cfg(10'h00A); tick(2);
        chk("R9 wake ignores master", irq_req, 1);
        wake_lvl = 0; tick(2);
        chk("R6 only wake passes master off", irq_req, 0);
        cleanup();
    endtask

    task automatic t_clear;
        force_fall(8'd10);
        tick(2);
        chk("R7 held before clear", cfg_rd[10], 1);
        wr_cfg(10'h30A);
        chk("R10 clear ends holdoff", cfg_rd[10], 0);
        chk("R10 line still low", irq_req, 0);
        tick();
        chk("R10 request reasserts", irq_req, 1);
        cleanup();
    endtask

    initial begin
        tick(3); rst_n = 1; tick(2);
        t_reset();
        t_latch();
        t_level();
        t_sw();
        t_master();
        t_hold(8'd3, 3 * DIV + 1, "R7");
        t_hold(8'd1, 1 * DIV + 1, "R7 short");
        t_hold(8'd0, 1, "R8");
        t_wake();
        t_clear();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule